// File: doc/BRIEF.md
# Zooming Scrolling Checkerboard Generator

This block produces a full-screen two-colour checkerboard whose cell size and horizontal and vertical position can change from one frame to the next. The pattern is never stored as a whole frame. When vertical blank begins, the block takes a copy of the cell size N and the X and Y offsets. It divides both offsets by N and then writes one line of packed pixels into an 80-byte line buffer, one byte per clock. A read port, driven by the external video timing, returns that same line for every visible raster line.

The vertical half of the checker comes from a single row-parity bit. A downstream palette uses this bit to invert its flashing colours. At frame start the line counter and the parity are preset from the Y offset. Each line-start pulse advances the counter, and the parity flips every N lines. As a result, each band of N lines shows the opposite colour pattern from the band above it. The block contains no palette lookup and no video timing generation.

Top module: `ckbZoomTop`

## Requirements
- R1: The block samples cellSize, xOffset and yOffset on the first clock at which vblank is seen high after being low, and holds them for the whole frame. Input changes after that clock have no effect until the next rising vblank.
- R2: A cellSize of 0 behaves exactly like a cellSize of 1.
- R3: Each buffer byte packs 4 pixels of 2 bits, with the leftmost pixel in bits [7:6] and the rightmost in bits [1:0]. Colour 0 is coded 2'b00 and colour 1 is coded 2'b11, so a solid byte reads 8'h00 or 8'hFF.
- R4: Pixel c of the line (c = 0..319, byte c/4) has colour ((c + X) div N) mod 2. This holds for every N, including N below 4, where one byte contains several colour changes.
- R5: The line buffer is written only while vblank is high. A fill completes within 100 clocks of the rising vblank. If vblank falls early, the fill stops, and the bytes not yet reached keep their previous contents.
- R6: On frameStart, the row parity becomes bit 0 of (Y div N) and the line counter becomes Y mod N.
- R7: After L lineStart pulses since frameStart, the row parity equals ((Y + L) div N) mod 2. The counter wraps to 0 and the parity toggles when a pulse arrives with the counter at N-1. frameStart takes priority over lineStart.
- R8: The row parity does not change on cycles without frameStart or lineStart.
- R9: pixByte presents buffer byte rdAddr one clock after rdAddr is applied. After reset the buffer holds 8'h00 and the parity is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vblank | input | 1 | High during vertical blank |
| frameStart | input | 1 | One-cycle pulse that presets the line counter and parity |
| lineStart | input | 1 | One-cycle pulse that advances to the next raster line |
| cellSize | input | 8 | Cell size N in pixels (0 is treated as 1) |
| xOffset | input | 9 | Horizontal scroll in pixels |
| yOffset | input | 8 | Vertical scroll in lines |
| rdAddr | input | 7 | Byte index of the line buffer to read (0..79) |
| pixByte | output | 8 | Packed pixels for byte rdAddr, one clock later |
| rowParity | output | 1 | Colour-inversion select for the current line |

## Verification
On every cycle, the assertions check the following: buffer writes stay inside vblank, the control strobes stay mutually exclusive, and the held frame parameters stay constant between captures. They also check that N is never zero, that the pixel countdown stays within 1..N during the fill, and that the parity holds without pulses and flips when the counter wraps. Only the bench scenarios can show that the whole 320-pixel pattern and the parity of all 256 lines match the arithmetic formulas for many sizes and offsets. The same holds for the claims that inputs changed during a frame are ignored and that a fill cut short by vblank leaves the tail of the buffer untouched.

// File: rtl/ckbPkg.sv
package ckbPkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch frame parameters
    logic divStart;  // launch offset divisions
    logic initFill;  // load countdown and colour for byte 0
    logic fillStep;  // write one byte and advance
  } ckbCtlT;
endpackage

// File: rtl/ckbDivider.sv
module ckbDivider #(
  parameter int DW = 9,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [NW-1:0] divisor,
  output logic [DW-1:0] quot,
  output logic [NW-1:0] rem,
  output logic          done
);
  localparam int CW = $clog2(DW + 1);

  logic [NW:0]   acc;
  logic [DW-1:0] quo;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [NW:0]   trial;
  logic          fits;

  assign trial = {acc[NW-1:0], quo[DW-1]};
  assign fits  = trial >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc  <= '0;
      quo  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      acc  <= '0;
      quo  <= dividend;
      cnt  <= CW'(DW);
      busy <= 1'b1;
      done <= 1'b0;
    end else if (busy) begin
      acc <= fits ? (trial - {1'b0, divisor}) : trial;
      quo <= {quo[DW-2:0], fits};
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign quot = quo;
  assign rem  = acc[NW-1:0];

  AST_DIV_NOT_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R4
endmodule

// File: rtl/ckbCtrl.sv
module ckbCtrl
  import ckbPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   vblank,
  input  logic   divDone,
  input  logic   lastByte,
  output ckbCtlT ctl
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DIV, S_INIT, S_FILL} stateT;

  stateT state, nextState;
  logic  vblankQ;
  logic  vblankRise;

  assign vblankRise = vblank && !vblankQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      vblankQ <= 1'b0;
    end else begin
      state   <= nextState;
      vblankQ <= vblank;
    end
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (state != S_IDLE && !vblank) begin
      nextState = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (vblankRise) begin
          ctl.capture = 1'b1;
          nextState   = S_START;
        end
        S_START: begin
          ctl.divStart = 1'b1;
          nextState    = S_DIV;
        end
        S_DIV: if (divDone) nextState = S_INIT;
        S_INIT: begin
          ctl.initFill = 1'b1;
          nextState    = S_FILL;
        end
        S_FILL: begin
          ctl.fillStep = 1'b1;
          if (lastByte) nextState = S_IDLE;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl)); // R5
  AST_FILL_FOLLOWS_INIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.initFill |=> (ctl.fillStep || !vblank)); // R5
endmodule

// File: rtl/ckbDatapath.sv
module ckbDatapath
  import ckbPkg::*;
#(
  parameter int CELL_W       = 8,
  parameter int X_W          = 9,
  parameter int Y_W          = 8,
  parameter int BYTES        = 80,
  parameter int PIX_PER_BYTE = 4,
  parameter int PIX_BITS     = 2,
  localparam int BYTE_W      = PIX_PER_BYTE * PIX_BITS,
  localparam int ADDR_W      = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ckbCtlT            ctl,
  input  logic              vblank,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic [CELL_W-1:0] cellSize,
  input  logic [X_W-1:0]    xOffset,
  input  logic [Y_W-1:0]    yOffset,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              divDone,
  output logic              lastByte,
  output logic [BYTE_W-1:0] pixByte,
  output logic              rowParity
);
  // Frame parameters held from vblank start
  logic [CELL_W-1:0] cellEff;
  logic [X_W-1:0]    xHeld;
  logic [Y_W-1:0]    yHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cellEff <= CELL_W'(1);
      xHeld   <= '0;
      yHeld   <= '0;
    end else if (ctl.capture) begin
      cellEff <= (cellSize == '0) ? CELL_W'(1) : cellSize;
      xHeld   <= xOffset;
      yHeld   <= yOffset;
    end
  end

  // Offset divisions by the cell size
  logic [X_W-1:0]    xQuot;
  logic [CELL_W-1:0] xRem;
  logic              xDone;
  logic [Y_W-1:0]    yQuot;
  logic [CELL_W-1:0] yRem;
  logic              yDone;

  ckbDivider #(.DW(X_W), .NW(CELL_W)) uXDiv (
    .clk(clk), .rstN(rstN), .start(ctl.divStart), .dividend(xHeld),
    .divisor(cellEff), .quot(xQuot), .rem(xRem), .done(xDone));

  ckbDivider #(.DW(Y_W), .NW(CELL_W)) uYDiv (
    .clk(clk), .rstN(rstN), .start(ctl.divStart), .dividend(yHeld),
    .divisor(cellEff), .quot(yQuot), .rem(yRem), .done(yDone));

  assign divDone = xDone && yDone;

  // Horizontal fill: countdown to next colour change plus current colour
  logic [CELL_W-1:0] remain;
  logic              color;
  logic [ADDR_W-1:0] byteIdx;
  logic [BYTE_W-1:0] newByte;
  logic [CELL_W-1:0] stepRemain [PIX_PER_BYTE+1];
  logic              stepColor  [PIX_PER_BYTE+1];

  assign stepRemain[0] = remain;
  assign stepColor[0]  = color;

  for (genvar p = 0; p < PIX_PER_BYTE; p++) begin : gPix
    assign newByte[BYTE_W-1-p*PIX_BITS -: PIX_BITS] = {PIX_BITS{stepColor[p]}};
    assign stepRemain[p+1] = (stepRemain[p] == CELL_W'(1)) ? cellEff
                                                            : stepRemain[p] - 1'b1;
    assign stepColor[p+1]  = (stepRemain[p] == CELL_W'(1)) ? !stepColor[p]
                                                            : stepColor[p];
  end

  assign lastByte = (byteIdx == ADDR_W'(BYTES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain  <= CELL_W'(1);
      color   <= 1'b0;
      byteIdx <= '0;
    end else if (ctl.initFill) begin
      remain  <= cellEff - xRem;
      color   <= xQuot[0];
      byteIdx <= '0;
    end else if (ctl.fillStep) begin
      remain  <= stepRemain[PIX_PER_BYTE];
      color   <= stepColor[PIX_PER_BYTE];
      byteIdx <= byteIdx + 1'b1;
    end
  end

  // Line buffer with a registered read port
  logic [BYTE_W-1:0] lineBuf [BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BYTES; i++) lineBuf[i] <= '0;
      pixByte <= '0;
    end else begin
      if (ctl.fillStep) lineBuf[byteIdx] <= newByte;
      pixByte <= (32'(rdAddr) < BYTES) ? lineBuf[rdAddr] : '0;
    end
  end

  // Vertical banding: line counter and row parity
  logic [CELL_W-1:0] lineCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt   <= '0;
      rowParity <= 1'b0;
    end else if (frameStart) begin
      lineCnt   <= yRem;
      rowParity <= yQuot[0];
    end else if (lineStart) begin
      if (lineCnt == cellEff - 1'b1) begin
        lineCnt   <= '0;
        rowParity <= !rowParity;
      end else begin
        lineCnt <= lineCnt + 1'b1;
      end
    end
  end

  AST_WR_IN_VBLANK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillStep |-> vblank); // R5
  AST_N_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    cellEff != '0); // R2
  AST_PARAMS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(cellEff) && $stable(xHeld) && $stable(yHeld))); // R1
  AST_REMAIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fillStep |-> (remain != '0 && remain <= cellEff)); // R4
  AST_PARITY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!lineStart && !frameStart) |=> $stable(rowParity)); // R8
  AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !frameStart && lineCnt == cellEff - 1'b1)
      |=> (rowParity != $past(rowParity))); // R7
endmodule

// File: rtl/ckbZoomTop.sv
module ckbZoomTop
  import ckbPkg::*;
#(
  parameter int CELL_W       = 8,
  parameter int X_W          = 9,
  parameter int Y_W          = 8,
  parameter int BYTES        = 80,
  parameter int PIX_PER_BYTE = 4,
  parameter int PIX_BITS     = 2,
  localparam int BYTE_W      = PIX_PER_BYTE * PIX_BITS,
  localparam int ADDR_W      = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vblank,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic [CELL_W-1:0] cellSize,
  input  logic [X_W-1:0]    xOffset,
  input  logic [Y_W-1:0]    yOffset,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] pixByte,
  output logic              rowParity
);
  ckbCtlT ctl;
  logic   divDone;
  logic   lastByte;

  ckbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .vblank(vblank), .divDone(divDone),
    .lastByte(lastByte), .ctl(ctl));

  ckbDatapath #(
    .CELL_W(CELL_W), .X_W(X_W), .Y_W(Y_W), .BYTES(BYTES),
    .PIX_PER_BYTE(PIX_PER_BYTE), .PIX_BITS(PIX_BITS)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vblank(vblank),
    .frameStart(frameStart), .lineStart(lineStart), .cellSize(cellSize),
    .xOffset(xOffset), .yOffset(yOffset), .rdAddr(rdAddr),
    .divDone(divDone), .lastByte(lastByte), .pixByte(pixByte),
    .rowParity(rowParity));
endmodule

// File: tb/tb_ckbZoomTop.sv
module tb_ckbZoomTop;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vblank = 1'b0;
  logic       frameStart = 1'b0;
  logic       lineStart = 1'b0;
  logic [7:0] cellSize = '0;
  logic [8:0] xOffset = '0;
  logic [7:0] yOffset = '0;
  logic [6:0] rdAddr = '0;
  logic [7:0] pixByte;
  logic       rowParity;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = !clk;  // 50 MHz

  ckbZoomTop dut (
    .clk(clk), .rstN(rstN), .vblank(vblank), .frameStart(frameStart),
    .lineStart(lineStart), .cellSize(cellSize), .xOffset(xOffset),
    .yOffset(yOffset), .rdAddr(rdAddr), .pixByte(pixByte),
    .rowParity(rowParity));

  function automatic int effN(int n);
    return (n == 0) ? 1 : n;
  endfunction

  // R3/R4 reference byte
  function automatic logic [7:0] expByte(int n, int x, int idx);
    logic [7:0] b = '0;
    for (int p = 0; p < 4; p++) begin
      if ((((idx * 4 + p + x) / effN(n)) % 2) == 1) b[7-2*p -: 2] = 2'b11;
    end
    return b;
  endfunction

  // R6/R7 reference parity
  function automatic logic expPar(int n, int y, int line);
    return ((((y + line) / effN(n)) % 2) == 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readByte(input int idx, output logic [7:0] val);
    rdAddr = 7'(idx);
    @(negedge clk);
    val = pixByte;
  endtask

  // Opens vblank with (n,x,y), scrambles inputs, holds vblank for hold clocks
  task automatic openFrame(input int n, input int x, input int y, input int hold);
    @(negedge clk);
    cellSize = 8'(n); xOffset = 9'(x); yOffset = 8'(y);
    vblank = 1'b1;
    repeat (2) @(negedge clk);
    // R1: later changes must be ignored
    cellSize = 8'($urandom); xOffset = 9'($urandom); yOffset = 8'($urandom);
    repeat (hold - 3) @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    vblank = 1'b0;
  endtask

  task automatic runFrame(input int n, input int x, input int y);
    logic [7:0] v;
    logic p0;
    openFrame(n, x, y, 100);
    check("R6 preset parity", int'(rowParity), int'(expPar(n, y, 0)));
    p0 = rowParity;
    for (int i = 0; i < 80; i++) begin
      readByte(i, v);
      check(n == 0 ? "R2 R4 byte" : "R3 R4 byte", int'(v), int'(expByte(n, x, i)));
    end
    check("R8 parity idle", int'(rowParity), int'(p0));
    for (int l = 1; l < 256; l++) begin
      lineStart = 1'b1;
      @(negedge clk);
      lineStart = 1'b0;
      check("R7 line parity", int'(rowParity), int'(expPar(n, y, l)));
    end
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(20240613));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset parity", int'(rowParity), 0);
    readByte(5, v);
    check("R9 reset buffer", int'(v), 0);

    runFrame(0, 5, 7);     // R2
    runFrame(1, 0, 0);
    runFrame(2, 3, 1);
    runFrame(3, 1, 2);
    runFrame(4, 2, 5);
    runFrame(5, 0, 0);
    runFrame(255, 511, 255);
    runFrame(7, 300, 100);
    runFrame(1, 0, 0);
    // R5: vblank cut short, tail of buffer keeps previous N=1 line
    openFrame(200, 0, 0, 30);
    readByte(0, v);
    check("R5 early bytes rewritten", int'(v), 8'h00);
    readByte(79, v);
    check("R5 tail untouched", int'(v), 8'h33);
    for (int f = 0; f < 30; f++) begin
      runFrame(int'($urandom % 48), int'($urandom % 512), int'($urandom % 256));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule